// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves one byte at a time over a three-wire clocked serial link: a shift clock, a data output and a data input. The processor writes a byte into the shift register, which starts a transfer. Eight shift-clock periods later the register holds the byte received from the far end, and an interrupt request is raised. The shift clock is either produced here, by dividing the system clock, or taken from the clock pin when another device is the clock master.

Each pin can be handed back to plain port use. One select returns the data-output and clock pins to the port latch values. A separate enable decides whether the ready pin carries the active-low handshake or its own port latch value. Tri-state pins are modelled as a value output plus an output-enable output. When the block generates the clock, the data pin stops driving once a transfer has finished.

Top module: `sio_sync_xcvr`

## Requirements
- R1: After reset, `irq` is 0, `sclk_out` is 1, `sout_oe` is 0 in serial mode, and `rdy_n` is 1 when the ready handshake is enabled.
- R2: With the internal clock, the shift-clock half period is H = 4 << min(`div_sel`, 5) system clocks. This gives divide ratios of 8, 16, 32, 64, 128 and 256, and codes 5 to 7 all give 256. The first falling edge appears H cycles after the write cycle.
- R3: Data leaves on `sout` least significant bit first. A new bit is presented only on a falling edge of the shift clock.
- R4: `sin` is sampled on each rising edge of the shift clock. After eight rising edges, `rdata` holds the received byte, with the first sampled bit in bit 0.
- R5: `irq` goes to 1 on the eighth rising edge. It stays 1 until a cycle with `irq_clr` high and no completion in the same cycle.
- R6: When `rdy_en` is 1, `rdy_n` goes to 0 in the cycle after a write and returns to 1 on the first falling shift-clock edge. When `rdy_en` is 0, `rdy_n` equals `port_rdy`.
- R7: With the internal clock, `sout_oe` drops to 0 on the cycle the transfer completes.
- R8: When `clk_src_ext` is 1, shifting follows edges of `sclk_in` after a two-stage synchronizer, `sclk_oe` is 0, and `sout_oe` stays 1 after completion.
- R9: When `pin_sel` is 0, `sout` and `sclk_out` equal `port_sout` and `port_sclk`, with their enables at 1.
- R10: A write during a transfer reloads the register and restarts the bit count and clock phase. Only the new byte completes, and it takes a full eight bits.
- R11: With the internal clock, `sclk_out` is 1 whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 1 | Write strobe for the shift register; starts a transfer |
| wdata | input | 8 | Byte to transmit |
| rdata | output | 8 | Shift register contents (received byte) |
| irq_clr | input | 1 | Clears the completion request |
| irq | output | 1 | Transfer-complete request |
| clk_src_ext | input | 1 | 1: shift clock from `sclk_in`; 0: divided system clock |
| div_sel | input | 3 | Internal clock divide select |
| rdy_en | input | 1 | Enables the ready handshake on `rdy_n` |
| pin_sel | input | 1 | 1: serial function on data/clock pins; 0: port latches |
| port_sout | input | 1 | Port latch value for the data pin |
| port_sclk | input | 1 | Port latch value for the clock pin |
| port_rdy | input | 1 | Port latch value for the ready pin |
| sin | input | 1 | Serial data input |
| sout | output | 1 | Serial data output value |
| sout_oe | output | 1 | Data output enable |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Shift clock output value |
| sclk_oe | output | 1 | Clock output enable |
| rdy_n | output | 1 | Active-low ready output, or port value |

## Verification
The assertions watch properties that must hold on every cycle. The idle-high clock, a held request, ready going low after a write and high by the first falling edge, output data changing only on falling edges, and the output enable dropping at the end of an internally clocked transfer are all checked continuously. Other behaviour can only be shown by the bench scenarios. These are the exact divide ratios, the bit order on the wire and in `rdata`, the restart on a mid-transfer write, synchronized external clocking, and the port fallback of each pin. For each of these the bench plays a slave device and compares whole bytes and edge timing.

// File: rtl/sio_sync_xcvr.sv
module sio_sync_xcvr #(
  parameter int W    = 8,
  parameter int DIVW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         irq_clr,
  output logic         irq,
  input  logic         clk_src_ext,
  input  logic [2:0]   div_sel,
  input  logic         rdy_en,
  input  logic         pin_sel,
  input  logic         port_sout,
  input  logic         port_sclk,
  input  logic         port_rdy,
  input  logic         sin,
  output logic         sout,
  output logic         sout_oe,
  input  logic         sclk_in,
  output logic         sclk_out,
  output logic         sclk_oe,
  output logic         rdy_n
);
  localparam int CW = $clog2(W);

  logic [W-1:0]    sr;
  logic [CW-1:0]   bitcnt;
  logic [DIVW-1:0] cnt, half;
  logic            active, sclk_q, rdy_q, drv_q, sout_q;
  logic            ext_s1, ext_s2, ext_prev;
  logic            tick, fall_ev, rise_ev, last;

  assign half    = DIVW'(4) << ((div_sel > 3'd5) ? 3'd5 : div_sel);
  assign tick    = active & ~clk_src_ext & (cnt == half - DIVW'(1));
  assign fall_ev = active & (clk_src_ext ? (ext_prev & ~ext_s2) : (tick & sclk_q));
  assign rise_ev = active & (clk_src_ext ? (~ext_prev & ext_s2) : (tick & ~sclk_q));
  assign last    = rise_ev & (bitcnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1   <= 1'b1;
      ext_s2   <= 1'b1;
      ext_prev <= 1'b1;
    end else begin
      ext_s1   <= sclk_in;
      ext_s2   <= ext_s1;
      ext_prev <= ext_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      bitcnt <= '0;
      cnt    <= '0;
      active <= 1'b0;
      sclk_q <= 1'b1;
      rdy_q  <= 1'b1;
      drv_q  <= 1'b0;
      sout_q <= 1'b1;
    end else if (wr_data) begin
      sr     <= wdata;
      bitcnt <= '0;
      cnt    <= '0;
      active <= 1'b1;
      sclk_q <= 1'b1;
      rdy_q  <= 1'b0;
      drv_q  <= 1'b1;
    end else begin
      if (active && !clk_src_ext) cnt <= tick ? '0 : cnt + DIVW'(1);
      if (tick) sclk_q <= ~sclk_q;
      if (fall_ev) begin
        sout_q <= sr[0];
        rdy_q  <= 1'b1;
      end
      if (rise_ev) begin
        sr     <= {sin, sr[W-1:1]};
        bitcnt <= bitcnt + CW'(1);
      end
      if (last) begin
        active <= 1'b0;
        if (!clk_src_ext) drv_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq <= 1'b0;
    else if (last && !wr_data) irq <= 1'b1;
    else if (irq_clr)          irq <= 1'b0;
  end

  assign rdata    = sr;
  assign sout     = pin_sel ? sout_q : port_sout;
  assign sout_oe  = pin_sel ? drv_q : 1'b1;
  assign sclk_out = pin_sel ? sclk_q : port_sclk;
  assign sclk_oe  = pin_sel ? ~clk_src_ext : 1'b1;
  assign rdy_n    = rdy_en ? rdy_q : port_rdy;
endmodule

// File: rtl/sio_sync_xcvr_chk.sv
module sio_sync_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_data,
  input logic irq_clr,
  input logic irq,
  input logic clk_src_ext,
  input logic active,
  input logic sclk_q,
  input logic rdy_q,
  input logic drv_q,
  input logic sout_q
);
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) irq && !irq_clr |=> irq); // R5
  AST_WR_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n) wr_data |=> !rdy_q); // R6
  AST_FALL_RDY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk_q) |-> rdy_q); // R6
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !active |-> sclk_q); // R11
  AST_HIZ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!clk_src_ext && $fell(active)) |-> !drv_q); // R7
  AST_SOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) (!clk_src_ext && !$stable(sout_q)) |-> $fell(sclk_q)); // R3
endmodule

bind sio_sync_xcvr sio_sync_xcvr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .irq_clr(irq_clr), .irq(irq),
  .clk_src_ext(clk_src_ext), .active(active), .sclk_q(sclk_q), .rdy_q(rdy_q),
  .drv_q(drv_q), .sout_q(sout_q)
);

// File: tb/sio_sync_xcvr_tb_top.sv
module sio_sync_xcvr_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_data = 0, irq_clr = 0, clk_src_ext = 0, rdy_en = 1, pin_sel = 1;
  logic port_sout = 0, port_sclk = 0, port_rdy = 0, sin = 0, sclk_in = 1;
  logic [7:0] wdata = 0;
  logic [2:0] div_sel = 0;
  logic [7:0] rdata;
  logic irq, sout, sout_oe, sclk_out, sclk_oe, rdy_n;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  sio_sync_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wdata(wdata), .rdata(rdata),
    .irq_clr(irq_clr), .irq(irq), .clk_src_ext(clk_src_ext), .div_sel(div_sel),
    .rdy_en(rdy_en), .pin_sel(pin_sel), .port_sout(port_sout), .port_sclk(port_sclk),
    .port_rdy(port_rdy), .sin(sin), .sout(sout), .sout_oe(sout_oe), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rdy_n(rdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_write(input logic [7:0] b);
    @(negedge clk);
    wr_data = 1; wdata = b;
    @(negedge clk);
    wr_data = 0;
  endtask

  // Acts as the slave; measures from the negedge just after the write edge.
  task automatic collect(input int h, input logic [7:0] exp_tx, input logic [7:0] rx, input string tag);
    logic [7:0] got = 0;
    int n = 0, i = 0, first = -1;
    logic prev = 1;
    chk(rdy_n == 0, "R6 rdy low after write", rdy_n, 0);
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
      if (prev && !sclk_out) begin
        if (first < 0) begin
          first = n;
          chk(rdy_n == 1, "R6 rdy high at first fall", rdy_n, 1);
        end
        if (i < 8) got[i] = sout;
        sin = rx[i % 8];
        i++;
      end
      prev = sclk_out;
    end
    chk(first == h, {tag, " R2 first fall delay"}, first, h);
    chk(n == 16 * h, {tag, " R5 irq at eighth rise"}, n, 16 * h);
    chk(got == exp_tx, {tag, " R3 lsb-first out"}, got, exp_tx);
    chk(rdata == rx, {tag, " R4 received byte"}, rdata, rx);
    chk(sout_oe == 0, {tag, " R7 hi-z after done"}, sout_oe, 0);
    chk(sclk_out == 1, {tag, " R11 idle high"}, sclk_out, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  task automatic t_reset;
    chk(irq == 0, "R1 irq", irq, 0);
    chk(sclk_out == 1, "R1 sclk", sclk_out, 1);
    chk(sout_oe == 0, "R1 sout_oe", sout_oe, 0);
    chk(rdy_n == 1, "R1 rdy_n", rdy_n, 1);
  endtask

  task automatic t_internal(input logic [2:0] d, input int h, input logic [7:0] tx, input logic [7:0] rx);
    div_sel = d;
    do_write(tx);
    collect(h, tx, rx, "int");
  endtask

  task automatic t_irq_hold;
    div_sel = 0;
    do_write(8'h3C);
    while (!irq) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(irq == 1, "R5 irq held", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(irq == 0, "R5 irq cleared", irq, 0);
  endtask

  task automatic t_restart;
    div_sel = 0;
    do_write(8'hFF);
    repeat (20) @(negedge clk);
    do_write(8'h96);
    chk(irq == 0, "R10 no irq from aborted byte", irq, 0);
    collect(4, 8'h96, 8'h5A, "R10 restart");
  endtask

  task automatic t_external(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got = 0;
    clk_src_ext = 1;
    do_write(tx);
    chk(sclk_oe == 0, "R8 clock pin is input", sclk_oe, 0);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 0; sin = rx[i];
      repeat (6) @(negedge clk);
      got[i] = sout;
      sclk_in = 1;
      repeat (6) @(negedge clk);
    end
    chk(irq == 1, "R8 ext irq", irq, 1);
    chk(rdata == rx, "R8 ext received", rdata, rx);
    chk(got == tx, "R8 ext transmitted", got, tx);
    chk(sout_oe == 1, "R8 ext keeps driving", sout_oe, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    clk_src_ext = 0;
  endtask

  task automatic t_ports;
    pin_sel = 0; rdy_en = 0;
    port_sout = 1; port_sclk = 0; port_rdy = 1;
    @(negedge clk);
    chk(sout == 1 && sout_oe == 1, "R9 sout port", sout, 1);
    chk(sclk_out == 0 && sclk_oe == 1, "R9 sclk port", sclk_out, 0);
    chk(rdy_n == 1, "R6 rdy port value", rdy_n, 1);
    port_sout = 0; port_sclk = 1; port_rdy = 0;
    @(negedge clk);
    chk(sout == 0 && sclk_out == 1, "R9 ports follow", {sout, sclk_out}, 1);
    chk(rdy_n == 0, "R6 rdy port follows", rdy_n, 0);
    pin_sel = 1; rdy_en = 1;
  endtask

  task automatic t_div_top;
    int n = 0;
    div_sel = 7;
    do_write(8'h01);
    while (sclk_out && n < 1000) begin @(negedge clk); n++; end
    chk(n == 128, "R2 code 7 gives 256", n, 128);
    while (!irq) @(negedge clk);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_internal(3'd0, 4, 8'hA5, 8'h3C);
    t_internal(3'd1, 8, 8'h81, 8'hE7);
    t_internal(3'd2, 16, 8'h0F, 8'h01);
    t_internal(3'd5, 128, 8'h6D, 8'hB2);
    t_div_top;
    t_irq_hold;
    t_restart;
    t_external(8'hC3, 8'h29);
    t_ports;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule